// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative TLB

This block translates 32-bit virtual addresses into 29-bit physical addresses through a fully associative main table of 64 entries. Each entry holds a virtual page number, a physical page number, an 8-bit address-space tag, a shared flag, a valid flag and its own 2-bit page size. Because the page size is stored per entry, each entry applies its own tag-compare mask and its own split between page number and page offset. The size encodings are 00 for 1 KB, 01 for 4 KB, 10 for 64 KB and 11 for 1 MB.

The block has three ports. The operand lookup port searches the main table directly and returns hit, miss or multiple-hit one cycle after a request. The instruction lookup port first searches a 4-entry instruction table. On a miss there, the block searches the main table, copies the single matching entry into the instruction table in round-robin order, and returns the result one cycle later. The load port writes one main-table entry. The index comes either from the request or from a free-running counter. Every load empties the instruction table, so stale copies cannot survive.

Top module: `multi_size_tlb`

## Requirements
- R1: After reset every entry in both tables is invalid, `d_vld_o` and `i_vld_o` are 0, and every lookup reports a miss.
- R2: A `d_req_i` sampled at a clock edge produces `d_vld_o` high for exactly the following cycle. In that cycle exactly one of `d_hit_o`, `d_miss_o` and `d_multi_o` is set. On a hit, `d_pa_o` holds the translation; otherwise `d_pa_o` is 0.
- R3: An entry of size 00, 01, 10 or 11 compares virtual bits [31:10], [31:12], [31:16] or [31:20] respectively. The physical address takes bits [28:k] from the stored page number (page number bit j is physical bit j+10) and bits [k-1:0] from the virtual address, where k is 10, 12, 16 or 20.
- R4: With `single_i`=0, an entry matches only if its tag equals `asid_i` or its shared flag is set.
- R5: With `single_i`=1, the tag compare is ignored.
- R6: If more than one valid entry matches, the lookup reports multiple-hit, with hit 0, miss 0 and address 0.
- R7: A load with `ld_rand_i`=0 writes entry `ld_idx_i`, replacing its previous contents. A load with `ld_valid_i`=0 removes a translation.
- R8: A load with `ld_rand_i`=1 writes the entry whose index equals the number of clock edges since reset release, modulo 64, at the edge that samples the load.
- R9: An instruction lookup that hits in the instruction table returns its result one cycle after the request.
- R10: An instruction lookup that misses in the instruction table returns its result two cycles after the request. A single main-table hit is copied into the instruction table. Requests arriving in the cycle the miss is being resolved are ignored.
- R11: Instruction-table refills replace entries in round-robin order, so the fifth distinct page evicts the oldest of the four.
- R12: Any load invalidates the whole instruction table, so the next instruction lookup goes to the main table and sees the new contents.
- R13: An instruction lookup that misses or multiply hits in the main table is reported after two cycles and leaves the instruction table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| single_i | input | 1 | 1: single virtual space, tag compare ignored |
| asid_i | input | 8 | Current address-space tag |
| ld_i | input | 1 | Load strobe |
| ld_rand_i | input | 1 | 1: index taken from free-running counter |
| ld_idx_i | input | 6 | Explicit load index |
| ld_valid_i | input | 1 | Valid flag of loaded entry |
| ld_shared_i | input | 1 | Shared flag of loaded entry |
| ld_size_i | input | 2 | Page size code of loaded entry |
| ld_asid_i | input | 8 | Tag of loaded entry |
| ld_vpn_i | input | 22 | Virtual bits [31:10] of loaded entry |
| ld_ppn_i | input | 19 | Physical bits [28:10] of loaded entry |
| d_req_i | input | 1 | Operand lookup request |
| d_va_i | input | 32 | Operand virtual address |
| d_vld_o | output | 1 | Operand result valid |
| d_hit_o | output | 1 | Operand single hit |
| d_miss_o | output | 1 | Operand miss |
| d_multi_o | output | 1 | Operand multiple hit |
| d_pa_o | output | 29 | Operand physical address |
| i_req_i | input | 1 | Instruction lookup request |
| i_va_i | input | 32 | Instruction virtual address |
| i_vld_o | output | 1 | Instruction result valid |
| i_hit_o | output | 1 | Instruction single hit |
| i_miss_o | output | 1 | Instruction miss |
| i_multi_o | output | 1 | Instruction multiple hit |
| i_pa_o | output | 29 | Instruction physical address |

## Verification
The hardest behaviour to reach from the ports is the instruction table's round-robin eviction. It is visible only as a change in latency, and it is disturbed by any load. The stimulus therefore writes all the needed main-table entries first. It then walks five distinct instruction pages without any load in between, and uses the one- or two-cycle result latency to tell which page was evicted. Random-index loads are checked by predicting the counter from a bench-side edge count, then invalidating the predicted index and observing that the translation disappears. The multiple-hit case is built by placing a 1 KB and a 1 MB page over the same address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 29;
  localparam int ASID_W = 8;
  localparam int OFF_W  = 10;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;

  typedef struct packed {
    logic              vld;
    logic              shr;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;

  // ones over the page-number bits a page of this size keeps
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] size);
    case (size)
      2'b00:   vpn_mask = '1;
      2'b01:   vpn_mask = {VPN_W{1'b1}} << 2;
      2'b10:   vpn_mask = {VPN_W{1'b1}} << 6;
      default: vpn_mask = {VPN_W{1'b1}} << 10;
    endcase
  endfunction

  function automatic logic [PPN_W-1:0] page_pa(input tlb_entry_t e,
                                               input logic [VPN_W-1:0] vpn);
    logic [VPN_W-1:0] m;
    m = vpn_mask(e.size);
    page_pa = (e.ppn & m[PPN_W-1:0]) | (vpn[PPN_W-1:0] & ~m[PPN_W-1:0]);
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
(
  input  tlb_entry_t        ent_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              single_i,
  output logic              hit_o
);
  logic [VPN_W-1:0] mask;
  logic tag_eq, asid_ok;

  always_comb begin
    mask    = vpn_mask(ent_i.size);
    tag_eq  = ((ent_i.vpn ^ vpn_i) & mask) == '0;
    asid_ok = single_i | ent_i.shr | (ent_i.asid == asid_i);
    hit_o   = ent_i.vld & tag_eq & asid_ok;
  end
endmodule

// File: rtl/tlb_search.sv
module tlb_search
  import tlb_pkg::*;
#(
  parameter int N = 64
) (
  input  tlb_entry_t [N-1:0] ents_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic               single_i,
  output logic               hit_o,
  output logic               multi_o,
  output tlb_entry_t         ent_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    tlb_entry_cmp u_cmp (
      .ent_i   (ents_i[g]),
      .vpn_i   (vpn_i),
      .asid_i  (asid_i),
      .single_i(single_i),
      .hit_o   (hit_vec[g])
    );
  end

  always_comb begin
    logic any, two;
    tlb_entry_t merged;
    any    = 1'b0;
    two    = 1'b0;
    merged = '0;
    for (int i = 0; i < N; i++) begin
      two    = two | (any & hit_vec[i]);
      any    = any | hit_vec[i];
      merged = merged | (ents_i[i] & {$bits(tlb_entry_t){hit_vec[i]}});
    end
    hit_o   = any & ~two;
    multi_o = two;
    ent_o   = two ? '0 : merged;
  end
endmodule

// File: rtl/tlb_wrap_ctr.sv
module tlb_wrap_ctr #(
  parameter int N = 64,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == W'(N - 1)) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/multi_size_tlb.sv
module multi_size_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT  = 64,
  parameter int N_ITLB = 4,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              single_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              ld_i,
  input  logic              ld_rand_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic              ld_valid_i,
  input  logic              ld_shared_i,
  input  logic [1:0]        ld_size_i,
  input  logic [ASID_W-1:0] ld_asid_i,
  input  logic [VPN_W-1:0]  ld_vpn_i,
  input  logic [PPN_W-1:0]  ld_ppn_i,
  input  logic              d_req_i,
  input  logic [VA_W-1:0]   d_va_i,
  output logic              d_vld_o,
  output logic              d_hit_o,
  output logic              d_miss_o,
  output logic              d_multi_o,
  output logic [PA_W-1:0]   d_pa_o,
  input  logic              i_req_i,
  input  logic [VA_W-1:0]   i_va_i,
  output logic              i_vld_o,
  output logic              i_hit_o,
  output logic              i_miss_o,
  output logic              i_multi_o,
  output logic [PA_W-1:0]   i_pa_o
);
  localparam int IW = (N_ITLB > 1) ? $clog2(N_ITLB) : 1;

  tlb_entry_t [N_ENT-1:0]  utlb_q;
  tlb_entry_t [N_ITLB-1:0] itlb_q;
  tlb_entry_t              ld_ent;
  logic [IDX_W-1:0]        rnd_cnt, wr_idx;
  logic [IW-1:0]           rr_ptr;

  // main table write
  always_comb begin
    ld_ent = '{vld: ld_valid_i, shr: ld_shared_i, size: ld_size_i,
               asid: ld_asid_i, vpn: ld_vpn_i, ppn: ld_ppn_i};
    wr_idx = ld_rand_i ? rnd_cnt : ld_idx_i;
  end

  tlb_wrap_ctr #(.N(N_ENT)) u_rnd (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .cnt_o(rnd_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   utlb_q <= '0;
    else if (ld_i) utlb_q[wr_idx] <= ld_ent;
  end

  // operand path
  logic       d_hit, d_multi;
  tlb_entry_t d_ent;

  tlb_search #(.N(N_ENT)) u_dsrch (
    .ents_i(utlb_q), .vpn_i(d_va_i[VA_W-1:OFF_W]), .asid_i(asid_i),
    .single_i(single_i), .hit_o(d_hit), .multi_o(d_multi), .ent_o(d_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_vld_o <= 1'b0; d_hit_o <= 1'b0; d_miss_o <= 1'b0;
      d_multi_o <= 1'b0; d_pa_o <= '0;
    end else begin
      d_vld_o <= d_req_i;
      if (d_req_i) begin
        d_hit_o   <= d_hit;
        d_multi_o <= d_multi;
        d_miss_o  <= ~d_hit & ~d_multi;
        d_pa_o    <= d_hit ? {page_pa(d_ent, d_va_i[VA_W-1:OFF_W]), d_va_i[OFF_W-1:0]} : '0;
      end
    end
  end

  // instruction path
  logic            it_hit, it_multi, ui_hit, ui_multi, pend_q, i_acc, refill;
  tlb_entry_t      it_ent, ui_ent;
  logic [VA_W-1:0] i_va_q;

  tlb_search #(.N(N_ITLB)) u_isrch (
    .ents_i(itlb_q), .vpn_i(i_va_i[VA_W-1:OFF_W]), .asid_i(asid_i),
    .single_i(single_i), .hit_o(it_hit), .multi_o(it_multi), .ent_o(it_ent)
  );

  // second compare bank on the main table, for refills
  tlb_search #(.N(N_ENT)) u_rsrch (
    .ents_i(utlb_q), .vpn_i(i_va_q[VA_W-1:OFF_W]), .asid_i(asid_i),
    .single_i(single_i), .hit_o(ui_hit), .multi_o(ui_multi), .ent_o(ui_ent)
  );

  assign i_acc  = i_req_i & ~pend_q;
  assign refill = pend_q & ui_hit & ~ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; i_va_q <= '0;
      i_vld_o <= 1'b0; i_hit_o <= 1'b0; i_miss_o <= 1'b0;
      i_multi_o <= 1'b0; i_pa_o <= '0;
    end else begin
      i_vld_o <= 1'b0;
      if (pend_q) begin
        pend_q    <= 1'b0;
        i_vld_o   <= 1'b1;
        i_hit_o   <= ui_hit;
        i_multi_o <= ui_multi;
        i_miss_o  <= ~ui_hit & ~ui_multi;
        i_pa_o    <= ui_hit ? {page_pa(ui_ent, i_va_q[VA_W-1:OFF_W]), i_va_q[OFF_W-1:0]} : '0;
      end else if (i_acc) begin
        if (it_hit) begin
          i_vld_o   <= 1'b1;
          i_hit_o   <= 1'b1;
          i_multi_o <= 1'b0;
          i_miss_o  <= 1'b0;
          i_pa_o    <= {page_pa(it_ent, i_va_i[VA_W-1:OFF_W]), i_va_i[OFF_W-1:0]};
        end else begin
          pend_q <= 1'b1;
          i_va_q <= i_va_i;
        end
      end
    end
  end

  tlb_wrap_ctr #(.N(N_ITLB)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(refill), .cnt_o(rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     itlb_q <= '0;
    else if (ld_i)   itlb_q <= '0;
    else if (refill) itlb_q[rr_ptr] <= ui_ent;
  end

  logic [N_ITLB-1:0] itlb_vld;
  always_comb
    for (int i = 0; i < N_ITLB; i++) itlb_vld[i] = itlb_q[i].vld;

  // a_r2_*: operand result timing and outcome
  a_r2_data_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |=> d_vld_o);
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_vld_o |-> $countones({d_hit_o, d_miss_o, d_multi_o}) == 1);
  a_r6_multi_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_vld_o && d_multi_o) |-> d_pa_o == '0);
  a_r9_itlb_hit_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_acc && it_hit) |=> (i_vld_o && i_hit_o && !pend_q));
  a_r10_miss_resolves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> (!pend_q && i_vld_o));
  a_r10_no_accept_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> $stable(i_va_q));
  a_r12_flush_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> itlb_vld == '0);
  a_r13_no_refill_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ui_hit) |=> $stable(itlb_q));
endmodule

// File: tb/test_multi_size_tlb.sv
module test_multi_size_tlb;
  logic        clk = 0, rst_n = 0;
  logic        single = 0;
  logic [7:0]  asid = 0;
  logic        ld = 0, ld_rand = 0, ld_valid = 0, ld_shared = 0;
  logic [5:0]  ld_idx = 0;
  logic [1:0]  ld_size = 0;
  logic [7:0]  ld_asid = 0;
  logic [21:0] ld_vpn = 0;
  logic [18:0] ld_ppn = 0;
  logic        d_req = 0, i_req = 0;
  logic [31:0] d_va = 0, i_va = 0;
  logic        d_vld, d_hit, d_miss, d_multi, i_vld, i_hit, i_miss, i_multi;
  logic [28:0] d_pa, i_pa;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  multi_size_tlb i_multi_size_tlb (
    .clk_i(clk), .rst_ni(rst_n), .single_i(single), .asid_i(asid),
    .ld_i(ld), .ld_rand_i(ld_rand), .ld_idx_i(ld_idx), .ld_valid_i(ld_valid),
    .ld_shared_i(ld_shared), .ld_size_i(ld_size), .ld_asid_i(ld_asid),
    .ld_vpn_i(ld_vpn), .ld_ppn_i(ld_ppn),
    .d_req_i(d_req), .d_va_i(d_va), .d_vld_o(d_vld), .d_hit_o(d_hit),
    .d_miss_o(d_miss), .d_multi_o(d_multi), .d_pa_o(d_pa),
    .i_req_i(i_req), .i_va_i(i_va), .i_vld_o(i_vld), .i_hit_o(i_hit),
    .i_miss_o(i_miss), .i_multi_o(i_multi), .i_pa_o(i_pa)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [28:0] epa(input logic [18:0] ppn, input logic [1:0] sz, input logic [31:0] va);
    int k;
    logic [28:0] m;
    k = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
    m = (29'h1 << k) - 1;
    return ({ppn, 10'b0} & ~m) | (va[28:0] & m);
  endfunction

  task automatic load(input logic [5:0] idx, input bit rnd, input logic [31:0] va,
                      input logic [18:0] ppn, input logic [7:0] a, input logic [1:0] sz,
                      input bit shr, input bit v, output logic [5:0] used);
    ld = 1; ld_rand = rnd; ld_idx = idx; ld_vpn = va[31:10]; ld_ppn = ppn;
    ld_asid = a; ld_size = sz; ld_shared = shr; ld_valid = v;
    used = rnd ? 6'(cyc % 64) : idx;
    @(negedge clk);
    ld = 0; ld_rand = 0;
  endtask

  // kind: 0 miss, 1 hit, 2 multi
  task automatic d_look(input logic [31:0] va, input int kind, input logic [28:0] pa, input string rq);
    logic [31:0] e;
    d_req = 1; d_va = va;
    @(negedge clk);
    d_req = 0;
    e = {kind == 1, kind == 0, kind == 2, (kind == 1) ? pa : 29'h0};
    chk(d_vld && {d_hit, d_miss, d_multi, d_pa} == e, rq, {d_vld, d_hit, d_miss, d_multi, d_pa}, {1'b1, e});
  endtask

  task automatic i_look(input logic [31:0] va, input int lat, input int kind,
                        input logic [28:0] pa, input string rq);
    int n;
    logic [31:0] e;
    i_req = 1; i_va = va;
    @(negedge clk);
    i_req = 0;
    n = 1;
    if (!i_vld) begin @(negedge clk); n = 2; end
    e = {kind == 1, kind == 0, kind == 2, (kind == 1) ? pa : 29'h0};
    chk(i_vld && n == lat && {i_hit, i_miss, i_multi, i_pa} == e, rq,
        {28'(n), i_vld, i_hit, i_miss, i_multi, i_pa}, {28'(lat), 1'b1, e});
  endtask

  task automatic t_reset;
    chk(!d_vld && !i_vld, "R1 outputs idle", {d_vld, i_vld}, 0);
    d_look(32'h1000_0400, 0, 0, "R1 empty data lookup");
    i_look(32'h1000_0400, 2, 0, 0, "R1 empty instr lookup");
  endtask

  task automatic t_sizes;
    logic [5:0] u;
    load(0, 0, 32'h1000_0400, 19'h00123, 1, 2'b00, 0, 1, u);
    load(1, 0, 32'h2000_0000, 19'h05432, 1, 2'b01, 0, 1, u);
    load(2, 0, 32'h3000_0000, 19'h2ABCD, 1, 2'b10, 0, 1, u);
    load(3, 0, 32'h4000_0000, 19'h7FFFF, 1, 2'b11, 0, 1, u);
    asid = 1;
    d_look(32'h1000_07FC, 1, epa(19'h00123, 0, 32'h1000_07FC), "R3 1KB hit");
    d_look(32'h1000_0000, 0, 0, "R3 1KB bit10 differs");
    d_look(32'h2000_0ABC, 1, epa(19'h05432, 1, 32'h2000_0ABC), "R3 4KB hit");
    d_look(32'h2000_1000, 0, 0, "R3 4KB bit12 differs");
    d_look(32'h3000_F123, 1, epa(19'h2ABCD, 2, 32'h3000_F123), "R3 64KB hit");
    d_look(32'h3001_0000, 0, 0, "R3 64KB bit16 differs");
    d_look(32'h400F_FFFF, 1, epa(19'h7FFFF, 3, 32'h400F_FFFF), "R3 1MB hit");
    d_look(32'h4010_0000, 0, 0, "R3 1MB bit20 differs");
  endtask

  task automatic t_asid;
    logic [5:0] u;
    load(4, 0, 32'h5000_0000, 19'h00050, 7, 2'b01, 0, 1, u);
    load(5, 0, 32'h6000_0000, 19'h00060, 9, 2'b01, 1, 1, u);
    asid = 5;
    d_look(32'h5000_0010, 0, 0, "R4 foreign tag misses");
    d_look(32'h6000_0010, 1, epa(19'h00060, 1, 32'h6000_0010), "R4 shared entry hits");
    asid = 7;
    d_look(32'h5000_0010, 1, epa(19'h00050, 1, 32'h5000_0010), "R4 own tag hits");
    asid = 5; single = 1;
    d_look(32'h5000_0010, 1, epa(19'h00050, 1, 32'h5000_0010), "R5 single mode ignores tag");
    single = 0;
  endtask

  task automatic t_multi;
    logic [5:0] u;
    load(6, 0, 32'h7000_0000, 19'h00070, 0, 2'b00, 1, 1, u);
    load(7, 0, 32'h7000_0000, 19'h00170, 0, 2'b11, 1, 1, u);
    d_look(32'h7000_0100, 2, 0, "R6 overlapping pages");
    load(7, 0, 32'h7000_0000, 19'h00170, 0, 2'b11, 1, 0, u);
    d_look(32'h7000_0100, 1, epa(19'h00070, 0, 32'h7000_0100), "R7 invalidate by index");
    load(6, 0, 32'h7000_0000, 19'h00071, 0, 2'b00, 1, 1, u);
    d_look(32'h7000_0100, 1, epa(19'h00071, 0, 32'h7000_0100), "R7 overwrite by index");
  endtask

  task automatic t_rand;
    logic [5:0] p, u;
    repeat (5) @(negedge clk);
    load(0, 1, 32'h8000_0000, 19'h00080, 0, 2'b01, 1, 1, p);
    d_look(32'h8000_0044, 1, epa(19'h00080, 1, 32'h8000_0044), "R8 random load visible");
    load(p, 0, 32'h8000_0000, 19'h00080, 0, 2'b01, 1, 0, u);
    d_look(32'h8000_0044, 0, 0, "R8 random index predicted");
  endtask

  task automatic t_ignore;
    logic [5:0] u;
    load(15, 0, 32'hB000_0000, 19'h000B0, 0, 2'b01, 1, 1, u);
    load(16, 0, 32'hC000_0000, 19'h000C0, 0, 2'b01, 1, 1, u);
    i_req = 1; i_va = 32'hB000_0008;
    @(negedge clk);
    chk(!i_vld, "R10 no result after one cycle on miss", i_vld, 0);
    i_va = 32'hC000_0008;  // arrives while resolving
    @(negedge clk);
    i_req = 0;
    chk(i_vld && i_hit && i_pa == epa(19'h000B0, 1, 32'hB000_0008), "R10 miss result at two cycles",
        {i_vld, i_hit, i_pa}, {2'b11, epa(19'h000B0, 1, 32'hB000_0008)});
    @(negedge clk);
    chk(!i_vld, "R10 request during pending ignored", i_vld, 0);
    i_look(32'hC000_0008, 2, 1, epa(19'h000C0, 1, 32'hC000_0008), "R10 ignored page not cached");
    i_look(32'hB000_0FF0, 1, 1, epa(19'h000B0, 1, 32'hB000_0FF0), "R9 refilled page hits");
  endtask

  task automatic t_rr;
    logic [5:0] u;
    for (int k = 0; k < 5; k++)
      load(6'(10 + k), 0, 32'h9000_0000 + 32'(k) * 32'h1000, 19'h00900 + 19'(k), 0, 2'b01, 1, 1, u);
    for (int k = 0; k < 4; k++)
      i_look(32'h9000_0004 + 32'(k) * 32'h1000, 2, 1,
             epa(19'h00900 + 19'(k), 1, 32'h9000_0004 + 32'(k) * 32'h1000), "R11 fill");
    i_look(32'h9000_0004, 1, 1, epa(19'h00900, 1, 32'h9000_0004), "R9 cached page");
    i_look(32'h9000_4004, 2, 1, epa(19'h00904, 1, 32'h9000_4004), "R11 fifth page");
    i_look(32'h9000_0004, 2, 1, epa(19'h00900, 1, 32'h9000_0004), "R11 oldest evicted");
    i_look(32'h9000_2004, 1, 1, epa(19'h00902, 1, 32'h9000_2004), "R11 third page kept");
  endtask

  task automatic t_flush;
    logic [5:0] u;
    load(10, 0, 32'h9000_0000, 19'h00ABC, 0, 2'b01, 1, 1, u);
    i_look(32'h9000_0004, 2, 1, epa(19'h00ABC, 1, 32'h9000_0004), "R12 load flushes copy");
    i_look(32'h9000_2004, 2, 1, epa(19'h00902, 1, 32'h9000_2004), "R12 all copies flushed");
  endtask

  task automatic t_imiss;
    i_look(32'hE000_0000, 2, 0, 0, "R13 main miss reported");
    i_look(32'hE000_0000, 2, 0, 0, "R13 miss not cached");
    d_look(32'h7000_0100, 1, epa(19'h00071, 0, 32'h7000_0100), "R2 data port still serves");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sizes();
    t_asid();
    t_multi();
    t_rand();
    t_ignore();
    t_rr();
    t_flush();
    t_imiss();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule